// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a clocked host to an asynchronous static RAM of 256K words by 16 bits that has separate enables for its two byte lanes. The host offers one access at a time through a request port. The port carries a write flag, an 18-bit word address, 16 bits of write data and a two-bit lane mask. The controller then drives the active-low strobes of the memory: select, write, output enable, upper-lane enable and lower-lane enable. It also drives the address bus and the write data onto a shared bidirectional data bus.

The memory has no clock, so each of its timing limits is turned into a whole number of controller cycles. A clock-period parameter divides each limit and the result is rounded up. The covered limits are address and output-enable access time, write pulse width, address and data setup before the end of a write, minimum cycle time, and the time the memory's outputs need to float.

A read returns its data on `rd_data`, registered on the last cycle of the access. Every access, read or write, ends with a one-cycle `done` pulse.

Top module: `asram_bridge`

## Requirements
- R1: While `rst_n` is low and right after it is released, all five memory strobes are high, `mem_dq_oe` is low, `req_ready` is high and `done` is low.
- R2: During a read, select and output enable are low and write enable is high. The lower-lane enable is the inverse of mask bit 0, which covers data bits 7:0. The upper-lane enable is the inverse of mask bit 1, which covers bits 15:8. A mask bit of 1 enables its lane.
- R3: A read holds output enable low for exactly ceil(max(55, 25) ns / period) cycles, 6 at a 10 ns clock. It returns the stored word in enabled lanes and zero in disabled lanes.
- R4: A write is preceded by one setup cycle in which select is low and the data bus is driven. Write enable is then low for at least ceil(35 ns / period) cycles, and only while select is low.
- R5: Address and select are stable for at least 40 ns, and write data for at least 25 ns, before write enable rises.
- R6: The address never changes while select and write enable are both low.
- R7: The data bus is never driven while output enable is low. After a read, the controller waits at least 20 ns after output enable rises before it drives the bus.
- R8: Every access lasts at least ceil(55 ns / period) cycles from acceptance to `done`.
- R9: `done` is high for one cycle per access. A request is accepted only while `req_ready` is high, and a request raised while the controller is busy has no effect on memory.
- R10: A write changes only the lanes enabled in its mask and leaves the other lane of the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host requests an access |
| req_ready | output | 1 | Controller idle; request accepted at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | Memory address bus |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_ub_n | output | 1 | Upper-lane enable, active low |
| mem_lb_n | output | 1 | Lower-lane enable, active low |
| mem_dq | inout | 16 | Memory data bus |
| mem_dq_oe | output | 1 | Controller drives `mem_dq` |

## Verification
The bench attaches a timed memory model that measures, in nanoseconds, write pulse width, address, select and data setup, address movement during a write, bus contention and the float gap after a read. A pulse that is one cycle short, or a write that starts driving right after a read, is reported at the exact violating edge. Until the access time has elapsed, the model returns inverted data, so a controller that captures early returns visibly wrong words. Masked writes followed by reads, a request raised while busy, and the first and last addresses show up lane mixing, missing zeroing, and accepted stray requests as mismatches against a shadow copy.

// File: rtl/asram_pkg.sv
`timescale 1ns/100ps
// Package: shared state type and helpers for turning nanosecond limits
// into clock-cycle counts. Assumes positive integer periods.
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_TURN,
        ST_WSET,
        ST_WPUL,
        ST_WREC
    } asram_st_e;

    // Cycles needed to cover ns at a clock period of per, rounded up
    function automatic int ns_to_cyc(input int ns, input int per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_countdown.sv
`timescale 1ns/100ps
// Module: phase timer. A load of N-1 makes the current phase last N cycles;
// expired is high once the count has reached zero. Assumes load values
// fit in CW bits.
module asram_countdown #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt;

    // Load a new phase length or count down toward zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/asram_lane_capture.sv
`timescale 1ns/100ps
// Module: read-data register, one byte lane per generate instance.
// Disabled lanes are stored as zero so a floating bus never reaches the host.
module asram_lane_capture #(
    parameter int LANES = 2,
    parameter int LW    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  logic [LANES-1:0]      lane_en,
    input  logic [LANES*LW-1:0]   bus_in,
    output logic [LANES*LW-1:0]   q
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Take the lane from the bus when enabled, else clear it
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[g*LW +: LW] <= '0;
            else if (capture)
                q[g*LW +: LW] <= lane_en[g] ? bus_in[g*LW +: LW] : '0;
        end
    end

endmodule

// File: rtl/asram_bridge.sv
`timescale 1ns/100ps
// Module: asram_bridge - host request port to asynchronous SRAM.
// Runs one access at a time. Every memory-facing output comes from a register.
// Phase lengths come from nanosecond limits divided by CLK_NS and rounded up.
// Assumes the host holds request fields stable while req_valid is high.
module asram_bridge
    import asram_pkg::*;
#(
    parameter int CLK_NS = 10,
    parameter int AW     = 18,
    parameter int LW     = 8,
    parameter int T_AA   = 55,
    parameter int T_OE   = 25,
    parameter int T_WP   = 35,
    parameter int T_AW   = 40,
    parameter int T_DW   = 25,
    parameter int T_CYC  = 55,
    parameter int T_HZ   = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [2*LW-1:0] req_wdata,
    input  logic [1:0]      req_mask,
    output logic            done,
    output logic [2*LW-1:0] rd_data,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_cs_n,
    output logic            mem_we_n,
    output logic            mem_oe_n,
    output logic            mem_ub_n,
    output logic            mem_lb_n,
    inout  wire  [2*LW-1:0] mem_dq,
    output logic            mem_dq_oe
);

    localparam int DW    = 2 * LW;
    localparam int RD_N  = imax(ns_to_cyc(T_AA, CLK_NS), ns_to_cyc(T_OE, CLK_NS));
    // The setup cycle already provides one cycle of address and data setup
    localparam int PW_N  = imax(ns_to_cyc(T_WP, CLK_NS),
                           imax(ns_to_cyc(T_AW, CLK_NS) - 1, ns_to_cyc(T_DW, CLK_NS) - 1));
    localparam int REC_N = imax(1, ns_to_cyc(T_CYC, CLK_NS) - 1 - PW_N);
    localparam int TA_N  = imax(1, ns_to_cyc(T_HZ, CLK_NS));
    localparam int CMAX  = imax(imax(RD_N, PW_N), imax(REC_N, TA_N));
    localparam int CW    = $clog2(CMAX + 1);

    asram_st_e       st, nxt;
    logic            ld;
    logic [CW-1:0]   ld_val;
    logic            expired;
    logic [DW-1:0]   wdat;
    logic            capture;

    asram_countdown #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .expired  (expired)
    );

    // Next phase and timer reload on each phase change
    always_comb begin
        nxt    = st;
        ld     = 1'b0;
        ld_val = '0;
        case (st)
            ST_IDLE: if (req_valid) begin
                ld = 1'b1;
                if (req_write) begin
                    nxt    = ST_WSET;
                    ld_val = '0;
                end else begin
                    nxt    = ST_RD;
                    ld_val = CW'(RD_N - 1);
                end
            end
            ST_RD:   if (expired) begin
                nxt = ST_TURN; ld = 1'b1; ld_val = CW'(TA_N - 1);
            end
            ST_TURN: if (expired) nxt = ST_IDLE;
            ST_WSET: if (expired) begin
                nxt = ST_WPUL; ld = 1'b1; ld_val = CW'(PW_N - 1);
            end
            ST_WPUL: if (expired) begin
                nxt = ST_WREC; ld = 1'b1; ld_val = CW'(REC_N - 1);
            end
            ST_WREC: if (expired) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Registered memory strobes, address, write data and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_cs_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            wdat      <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (req_valid) begin
                    mem_addr <= req_addr;
                    mem_cs_n <= 1'b0;
                    mem_ub_n <= ~req_mask[1];
                    mem_lb_n <= ~req_mask[0];
                    if (req_write) begin
                        wdat      <= req_wdata;
                        mem_dq_oe <= 1'b1;
                    end else begin
                        mem_oe_n  <= 1'b0;
                    end
                end
                ST_RD: if (expired) begin
                    mem_cs_n <= 1'b1;
                    mem_oe_n <= 1'b1;
                    mem_ub_n <= 1'b1;
                    mem_lb_n <= 1'b1;
                    done     <= 1'b1;
                end
                ST_WSET: if (expired) mem_we_n <= 1'b0;
                ST_WPUL: if (expired) mem_we_n <= 1'b1;
                ST_WREC: if (expired) begin
                    mem_cs_n  <= 1'b1;
                    mem_ub_n  <= 1'b1;
                    mem_lb_n  <= 1'b1;
                    mem_dq_oe <= 1'b0;
                    done      <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign capture   = (st == ST_RD) && expired;
    assign req_ready = (st == ST_IDLE);
    assign mem_dq    = mem_dq_oe ? wdat : {DW{1'bz}};

    asram_lane_capture #(.LANES(2), .LW(LW)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .lane_en ({~mem_ub_n, ~mem_lb_n}),
        .bus_in  (mem_dq),
        .q       (rd_data)
    );

    // Checker counters: cycles with write enable low, cycles since output enable rose
    logic [CW:0] we_low_cnt, oe_hi_cnt;
    localparam logic [CW:0] PW_L = (CW+1)'(PW_N);
    localparam logic [CW:0] TA_L = (CW+1)'(TA_N);

    // Measure pulse width and float gap for the assertions below
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
            oe_hi_cnt  <= '1;
        end else begin
            we_low_cnt <= mem_we_n ? '0 : ((we_low_cnt == '1) ? we_low_cnt : we_low_cnt + 1'b1);
            oe_hi_cnt  <= !mem_oe_n ? '0 : ((oe_hi_cnt == '1) ? oe_hi_cnt : oe_hi_cnt + 1'b1);
        end
    end

    AST_DRIVE_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n); // R7
    AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_hi_cnt >= TA_L)); // R7
    AST_WE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n); // R4
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt >= PW_L)); // R4
    AST_RD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_cs_n)); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !mem_we_n && $past(!mem_cs_n && !mem_we_n)) |-> $stable(mem_addr)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

endmodule

// File: tb/asram_bridge_test.sv
`timescale 1ns/100ps
// Bench: controller against a timed behavioural memory model, directed
// corners plus seeded random accesses checked against a shadow copy.
module asram_bridge_test;

    localparam int CLK_NS  = 10;
    localparam int RD_EXP  = (55 + CLK_NS - 1) / CLK_NS;
    localparam int PW_EXP  = (35 + CLK_NS - 1) / CLK_NS;
    localparam int CYC_EXP = (55 + CLK_NS - 1) / CLK_NS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = 2'b00;
    logic        req_ready, done, mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [15:0] rd_data;
    logic [17:0] mem_addr;
    wire  [15:0] mem_dq;

    int total = 0, bad = 0;

    always #(CLK_NS / 2.0) clk = ~clk;

    asram_bridge #(.CLK_NS(CLK_NS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .done(done), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq(mem_dq), .mem_dq_oe(mem_dq_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [15:0] mm [int unsigned];
    logic [15:0] shadow [int unsigned];
    realtime t_addr = 0, t_cs = 0, t_oe = 0, t_oe_rise = -1000, t_wef = 0, t_dat = 0;
    logic        mod_lo_en = 1'b0, mod_hi_en = 1'b0;
    logic [15:0] mod_q = '0;

    assign mem_dq[7:0]  = mod_lo_en ? mod_q[7:0]  : 8'hzz;
    assign mem_dq[15:8] = mod_hi_en ? mod_q[15:8] : 8'hzz;

    // R6: address moves only while unselected or write enable high
    always @(mem_addr) begin
        if (rst_n && !mem_cs_n && !mem_we_n)
            chk(1'b0, "R6 addr moved in write", 32'(mem_addr), 32'(0));
        t_addr = $realtime;
    end
    always @(negedge mem_cs_n) t_cs = $realtime;
    always @(negedge mem_oe_n) t_oe = $realtime;
    always @(posedge mem_oe_n) t_oe_rise = $realtime;
    always @(negedge mem_we_n) t_wef = $realtime;
    always @(mem_dq) if (mem_dq_oe) t_dat = $realtime;

    // R7: controller drives only 20 ns or more after output enable rose
    always @(posedge mem_dq_oe)
        chk(($realtime - t_oe_rise) >= 20.0, "R7 float gap", 32'($rtoi($realtime - t_oe_rise)), 32'(20));

    // R4/R5: end-of-write timing, then store enabled lanes
    always @(posedge mem_we_n) begin
        if (rst_n && !mem_cs_n) begin
            logic [15:0] old;
            chk(($realtime - t_wef) >= 35.0, "R4 pulse width", 32'($rtoi($realtime - t_wef)), 32'(35));
            chk(($realtime - t_addr) >= 40.0 && ($realtime - t_cs) >= 40.0, "R5 addr setup",
                32'($rtoi($realtime - t_addr)), 32'(40));
            chk(($realtime - t_dat) >= 25.0, "R5 data setup", 32'($rtoi($realtime - t_dat)), 32'(25));
            old = mm.exists(int'(mem_addr)) ? mm[int'(mem_addr)] : 16'h0;
            if (!mem_lb_n) old[7:0]  = mem_dq[7:0];
            if (!mem_ub_n) old[15:8] = mem_dq[15:8];
            mm[int'(mem_addr)] = old;
        end
    end

    // Read drive, polled between clock edges; inverted data until access time met
    initial begin
        #0.5;
        forever begin
            logic sel, ok;
            logic [15:0] w;
            #1;
            sel = !mem_cs_n && !mem_oe_n && mem_we_n;
            ok  = ($realtime - t_addr) >= 55.0 && ($realtime - t_cs) >= 55.0 && ($realtime - t_oe) >= 25.0;
            w   = mm.exists(int'(mem_addr)) ? mm[int'(mem_addr)] : 16'h0;
            mod_q     = ok ? w : ~w;
            mod_lo_en = sel && !mem_lb_n;
            mod_hi_en = sel && !mem_ub_n;
            if (mem_dq_oe && (mod_lo_en || mod_hi_en))
                chk(1'b0, "R7 bus contention", 32'(1), 32'(0));
        end
    end

    // ---------------- host-side operation ----------------
    function automatic logic [15:0] lane_mask(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    task automatic do_op(input bit w, input logic [17:0] a, input logic [15:0] d,
                         input logic [1:0] m, input bit poke);
        int n = 0, oe_lo = 0, we_lo = 0;
        bit strobe_ok = 1'b1;
        logic [15:0] old, exp;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && n < 60) begin
            n++;
            if (!mem_oe_n) oe_lo++;
            if (!mem_we_n) we_lo++;
            if (!w && (mem_cs_n || mem_oe_n || !mem_we_n || mem_ub_n != ~m[1] || mem_lb_n != ~m[0]))
                strobe_ok = 1'b0;
            if (poke && n == 2) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 18'h1;
                req_wdata = ~d; req_mask = 2'b11;
            end
            if (poke && n == 3) req_valid = 1'b0;
            @(negedge clk);
        end
        chk(done, "R9 done seen", 32'(done), 32'(1));
        chk(n >= CYC_EXP, "R8 cycle time", 32'(n), 32'(CYC_EXP));
        old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
        if (w) begin
            chk(we_lo >= PW_EXP, "R4 we low cycles", 32'(we_lo), 32'(PW_EXP));
            shadow[int'(a)] = (old & ~lane_mask(m)) | (d & lane_mask(m));
        end else begin
            exp = old & lane_mask(m);
            chk(strobe_ok, "R2 read strobes", 32'(strobe_ok), 32'(1));
            chk(oe_lo == RD_EXP, "R3 oe low cycles", 32'(oe_lo), 32'(RD_EXP));
            chk(rd_data == exp, "R3 read data", 32'(rd_data), 32'(exp));
        end
        @(negedge clk);
        chk(!done, "R9 done one cycle", 32'(done), 32'(0));
    endtask

    logic [17:0] pool [8];

    initial begin
        pool[0] = 18'h0;     pool[1] = 18'h1;     pool[2] = 18'h2;     pool[3] = 18'h3;
        pool[4] = 18'h155;   pool[5] = 18'h2AA;   pool[6] = 18'h3FFFE; pool[7] = 18'h3FFFF;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe && !done,
            "R1 strobes in reset", 32'({mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, done}),
            32'(7'b1111100));
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_cs_n && !mem_dq_oe, "R1 idle after reset",
            32'({req_ready, mem_cs_n, mem_dq_oe}), 32'(3'b110));
        // Fill the pool with full-word writes, corners included
        for (int i = 0; i < 8; i++) do_op(1'b1, pool[i], 16'hA500 ^ 16'(i * 16'h1111), 2'b11, 1'b0);
        for (int i = 0; i < 8; i++) do_op(1'b0, pool[i], 16'h0, 2'b11, 1'b0);
        // R10: lane-only writes keep the other lane
        do_op(1'b1, 18'h3FFFF, 16'h12EF, 2'b01, 1'b0);
        do_op(1'b0, 18'h3FFFF, 16'h0, 2'b11, 1'b0);
        do_op(1'b1, 18'h0, 16'hBE34, 2'b10, 1'b0);
        do_op(1'b0, 18'h0, 16'h0, 2'b11, 1'b0);
        // R3: partial-mask reads return zero in the disabled lane
        do_op(1'b0, 18'h0, 16'h0, 2'b01, 1'b0);
        do_op(1'b0, 18'h0, 16'h0, 2'b10, 1'b0);
        // R9: request raised while busy must not write address ^1
        do_op(1'b1, 18'h2, 16'h7777, 2'b11, 1'b1);
        do_op(1'b0, 18'h3, 16'h0, 2'b11, 1'b0);
        do_op(1'b0, 18'h2, 16'h0, 2'b11, 1'b1);
        do_op(1'b0, 18'h3, 16'h0, 2'b11, 1'b0);
        // Read immediately followed by write exercises the float gap (R7)
        do_op(1'b0, 18'h155, 16'h0, 2'b11, 1'b0);
        do_op(1'b1, 18'h155, 16'h4321, 2'b11, 1'b0);
        // Random mix
        for (int k = 0; k < 200; k++) begin
            logic [1:0] m;
            m = 2'($urandom_range(1, 3));
            do_op(1'($urandom_range(0, 1)), pool[$urandom_range(0, 7)], 16'($urandom), m, 1'b0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * CLK_NS);
        chk(1'b0, "watchdog", 32'(0), 32'(1));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule